// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block gives a host a two-address window into a bank of byte-wide configuration registers on a simple I/O bus. The bus carries a 16-bit address, separate write and read strobes and one data byte per access. The window sits at a base address chosen by two strap pins. The straps are sampled while reset is held, and the value present in the last reset cycle is kept. The block starts in run state. In run state the low address of the window is only a write target, and it listens for a single unlock byte.

Once the unlock byte arrives, the block moves to configuration state. The low address then becomes a readable and writable index pointer. The high address then reads and writes the register that the pointer selects. Two entries of the bank hold the window's base address, so software can move the window while it is open. A separate lock byte written to the low address returns the block to run state. Any access the block does not claim leaves the claim flag low and the read bus at zero, so other devices on the bus can answer it.

Top module: `cfgp_ctrl`

## Requirements
- R1: After reset the block is in run state. In run state no read is claimed, and neither are accesses to base+1: `claim_o` stays 0 and `rdata_o` stays 0.
- R2: The strap value present in the last cycle of reset sets the base. `strap_i[0]` picks the low byte (0 gives 0x2E, 1 gives 0x4E). `strap_i[1]` picks the high byte (0 gives 0x00, 1 gives 0x16). Strap changes after reset have no effect.
- R3: In run state, writing 0x55 to base+0 is claimed and enters configuration state.
- R4: In run state, a write to base+0 of any byte other than 0x55 is not claimed and leaves the block in run state.
- R5: In configuration state, a write of any byte other than 0xAA to base+0 is claimed and loads the index. This includes 0x55. A read of base+0 returns the index.
- R6: In configuration state, a write to base+1 stores the byte into the bank entry selected by the index. A read of base+1 returns that entry. The bank has 256 entries.
- R7: In configuration state, writing 0xAA to base+0 is claimed and returns the block to run state. The index keeps its value and is readable again after the next unlock.
- R8: Index 0x12 holds the base low byte and index 0x13 the high byte. Both read back the strap base after reset. Writing either one moves the window, starting with the next strobe.
- R9: An access that is not claimed, including any address outside the window, gives `claim_o` = 0 and `rdata_o` = 0.
- R10: The response to a strobe (`claim_o`, plus `rdata_o` for reads) appears in the cycle after the strobe and lasts one cycle. A claimed write returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| strap_i | input | 2 | Strap pins selecting the default base |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe; has priority over `rd_i` |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not claimed |
| claim_o | output | 1 | High when the previous strobe was claimed |

## Verification
Two functions meet in one cycle when a data-port write to index 0x12 or 0x13 relocates the window. That write is decoded against the old base, and it changes the base at the same clock edge. The bench provokes this by writing a new low byte and then a new high byte. It then strobes both the old and the new addresses on the next accesses. The judgement is that only the new address is claimed, that the old one answers zero, and that the relocated registers read back the written bytes.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  localparam int          BYTE_W      = 8;
  localparam logic [7:0]  KEY_UNLOCK  = 8'h55;
  localparam logic [7:0]  KEY_LOCK    = 8'hAA;
  localparam logic [7:0]  SLOT_BASE_L = 8'h12;
  localparam logic [7:0]  SLOT_BASE_H = 8'h13;

  // Default window base from the strap pair: bit 0 -> low byte, bit 1 -> high byte
  function automatic logic [15:0] strap_to_base(input logic [1:0] s);
    logic [7:0] lo;
    logic [7:0] hi;
    lo = s[0] ? 8'h4E : 8'h2E;
    hi = s[1] ? 8'h16 : 8'h00;
    return {hi, lo};
  endfunction
endpackage

// File: rtl/cfgp_match.sv
`timescale 1ns/1ps
module cfgp_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit_idx,
  output logic          hit_dat
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    hit_idx = (addr == base);
    hit_dat = (addr == (base + ONE));
  end
endmodule

// File: rtl/cfgp_bank.sv
`timescale 1ns/1ps
module cfgp_bank #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfgp_ctrl.sv
`timescale 1ns/1ps
module cfgp_ctrl #(
  parameter int DATA_W = cfgp_pkg::BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          strap_i,
  input  logic [2*DATA_W-1:0] addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                claim_o
);
  import cfgp_pkg::*;

  localparam int ADDR_W = 2 * DATA_W;

  logic              cfg_q;
  logic [DATA_W-1:0] idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              claim_q;
  logic              mem_sel_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] bank_q;
  logic              hit_idx;
  logic              hit_dat;
  logic              bank_we;

  cfgp_match #(.AW(ADDR_W)) u_match (
    .addr    (addr_i),
    .base    (base_q),
    .hit_idx (hit_idx),
    .hit_dat (hit_dat)
  );

  assign bank_we = wr_i && cfg_q && hit_dat;

  cfgp_bank #(.DW(DATA_W), .IW(DATA_W)) u_bank (
    .clk   (clk),
    .we    (bank_we),
    .waddr (idx_q),
    .wdata (wdata_i),
    .raddr (idx_q),
    .rdata (bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= 1'b0;
      idx_q     <= '0;
      base_q    <= strap_to_base(strap_i);
      claim_q   <= 1'b0;
      mem_sel_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      claim_q   <= 1'b0;
      mem_sel_q <= 1'b0;
      hold_q    <= '0;
      if (wr_i) begin
        if (hit_idx) begin
          if (!cfg_q) begin
            if (wdata_i == KEY_UNLOCK) begin
              cfg_q   <= 1'b1;
              claim_q <= 1'b1;
            end
          end else begin
            claim_q <= 1'b1;
            if (wdata_i == KEY_LOCK) cfg_q <= 1'b0;
            else                     idx_q <= wdata_i;
          end
        end else if (hit_dat && cfg_q) begin
          claim_q <= 1'b1;
          if (idx_q == SLOT_BASE_L) base_q[DATA_W-1:0]      <= wdata_i;
          if (idx_q == SLOT_BASE_H) base_q[ADDR_W-1:DATA_W] <= wdata_i;
        end
      end else if (rd_i && cfg_q) begin
        if (hit_idx) begin
          claim_q <= 1'b1;
          hold_q  <= idx_q;
        end else if (hit_dat) begin
          claim_q <= 1'b1;
          if (idx_q == SLOT_BASE_L)      hold_q <= base_q[DATA_W-1:0];
          else if (idx_q == SLOT_BASE_H) hold_q <= base_q[ADDR_W-1:DATA_W];
          else                           mem_sel_q <= 1'b1;
        end
      end
    end
  end

  assign claim_o = claim_q;
  assign rdata_o = mem_sel_q ? bank_q : hold_q;
endmodule

// File: rtl/cfgp_ctrl_chk.sv
`timescale 1ns/1ps
module cfgp_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        claim_o,
  input logic        cfg_q,
  input logic        hit_idx,
  input logic        hit_dat,
  input logic [7:0]  idx_q,
  input logic [15:0] base_q
);
  assert_unclaimed_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !claim_o |-> (rdata_o == 8'h00));

  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !rd_i) |=> !claim_o);

  assert_run_read_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q && rd_i && !wr_i) |=> !claim_o);

  assert_unlock_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q && wr_i && hit_idx && wdata_i == 8'h55) |=> (cfg_q && claim_o));

  assert_run_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q && !(wr_i && hit_idx && wdata_i == 8'h55)) |=> !cfg_q);

  assert_index_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q && wr_i && hit_idx && wdata_i != 8'hAA) |=> (claim_o && idx_q == $past(wdata_i)));

  assert_lock_keeps_index_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q && wr_i && hit_idx && wdata_i == 8'hAA) |=> (!cfg_q && $stable(idx_q)));

  assert_relocate_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_q && wr_i && hit_dat && idx_q == 8'h12) |=> (base_q[7:0] == $past(wdata_i)));

  assert_relocate_high_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_q && wr_i && hit_dat && idx_q == 8'h13) |=> (base_q[15:8] == $past(wdata_i)));
endmodule

bind cfgp_ctrl cfgp_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .claim_o (claim_o),
  .cfg_q   (cfg_q),
  .hit_idx (hit_idx),
  .hit_dat (hit_dat),
  .idx_q   (idx_q),
  .base_q  (base_q)
);

// File: tb/test_cfgp_ctrl.sv
`timescale 1ns/1ps
module test_cfgp_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  strap_i = 2'b00;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        claim_o;

  always #2.5 clk = ~clk;

  cfgp_ctrl i_cfgp_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strap_i (strap_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .claim_o (claim_o)
  );

  typedef struct {
    logic       claim;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t  sb[$];
  exp_t  cur;
  int    total = 0;
  int    bad = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  function automatic logic [15:0] exp_base(input logic [1:0] s);
    return {(s[1] ? 8'h16 : 8'h00), (s[0] ? 8'h4E : 8'h2E)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic c, input logic [7:0] d,
                       input logic ec, input logic [7:0] ed);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got claim=%0b data=%02h, expected claim=%0b data=%02h", tag, c, d, ec, ed);
    end
  endtask

  // monitor: one cycle after each strobe, compare against the scoreboard
  always @(posedge clk) begin
    #1;
    if (!rst && mon_on) begin
      if (sb.size() > 0) begin
        cur = sb.pop_front();
        check(claim_o === cur.claim && rdata_o === cur.data, cur.tag,
              claim_o, rdata_o, cur.claim, cur.data);
      end else begin
        check(claim_o === 1'b0 && rdata_o === 8'h00, "R10 idle cycle",
              claim_o, rdata_o, 1'b0, 8'h00);
      end
    end
  end

  task automatic acc(input bit w, input logic [15:0] a, input logic [7:0] d,
                     input logic ec, input logic [7:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    wr_i = w; rd_i = !w; addr_i = a; wdata_i = d;
    e.claim = ec; e.data = ed; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] s);
    mon_on = 1'b0;
    @(negedge clk);
    rst = 1'b1; strap_i = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    strap_i = ~s;
    mon_on = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] b;
    do_reset(2'b00);
    b = exp_base(2'b00);
    // R1: run state after reset
    acc(0, b,      8'h00, 0, 8'h00, "R1 read base+0 in run");
    acc(0, b + 1,  8'h00, 0, 8'h00, "R1 read base+1 in run");
    acc(1, b + 1,  8'h77, 0, 8'h00, "R1 write base+1 in run");
    // R4: non-key writes ignored
    acc(1, b,      8'h00, 0, 8'h00, "R4 write 00 in run");
    acc(1, b,      8'hAA, 0, 8'h00, "R4 write AA in run");
    acc(0, b + 1,  8'h00, 0, 8'h00, "R4 still run");
    // R3: unlock
    acc(1, b,      8'h55, 1, 8'h00, "R3 unlock claimed");
    acc(0, b,      8'h00, 1, 8'h00, "R5 index after reset");
    // R5: index
    acc(1, b,      8'h05, 1, 8'h00, "R5 index write");
    acc(0, b,      8'h00, 1, 8'h05, "R5 index read");
    // R6: bank
    acc(1, b + 1,  8'h3C, 1, 8'h00, "R6 data write");
    acc(0, b + 1,  8'h00, 1, 8'h3C, "R6 data read");
    acc(1, b,      8'hFF, 1, 8'h00, "R6 index FF");
    acc(1, b + 1,  8'hC3, 1, 8'h00, "R6 write top entry");
    acc(1, b,      8'h05, 1, 8'h00, "R6 index back");
    acc(0, b + 1,  8'h00, 1, 8'h3C, "R6 entry 05 kept");
    acc(1, b,      8'hFF, 1, 8'h00, "R6 index FF again");
    acc(0, b + 1,  8'h00, 1, 8'hC3, "R6 entry FF read");
    // R5: 0x55 in config is an index
    acc(1, b,      8'h55, 1, 8'h00, "R5 55 as index");
    acc(0, b,      8'h00, 1, 8'h55, "R5 index 55 read");
    // R9: outside window
    acc(0, 16'h1234, 8'h00, 0, 8'h00, "R9 foreign read");
    acc(1, 16'h1234, 8'h9A, 0, 8'h00, "R9 foreign write");
    acc(0, b + 2,  8'h00, 0, 8'h00, "R9 base+2 read");
    // R8: base registers
    acc(1, b,      8'h12, 1, 8'h00, "R8 index 12");
    acc(0, b + 1,  8'h00, 1, b[7:0], "R8 base low after reset");
    acc(1, b,      8'h13, 1, 8'h00, "R8 index 13");
    acc(0, b + 1,  8'h00, 1, b[15:8], "R8 base high after reset");
    // R7: lock, index kept
    acc(1, b,      8'hAA, 1, 8'h00, "R7 lock claimed");
    acc(0, b + 1,  8'h00, 0, 8'h00, "R7 data silent after lock");
    acc(0, b,      8'h00, 0, 8'h00, "R7 index silent after lock");
    acc(1, b,      8'h55, 1, 8'h00, "R7 re-unlock");
    acc(0, b,      8'h00, 1, 8'h13, "R7 index kept");
    // R8: relocation
    acc(1, b,      8'h12, 1, 8'h00, "R8 index 12 again");
    acc(1, b + 1,  8'h80, 1, 8'h00, "R8 move low byte");
    acc(0, b,      8'h00, 0, 8'h00, "R8 old base dead");
    acc(0, 16'h0080, 8'h00, 1, 8'h12, "R8 new base index");
    acc(0, 16'h0081, 8'h00, 1, 8'h80, "R8 new low byte");
    acc(1, 16'h0080, 8'h13, 1, 8'h00, "R8 index 13 new");
    acc(1, 16'h0081, 8'h01, 1, 8'h00, "R8 move high byte");
    acc(0, 16'h0081, 8'h00, 0, 8'h00, "R8 second old base dead");
    acc(0, 16'h0181, 8'h00, 1, 8'h01, "R8 new high byte");
    // R2: all strap settings, straps flipped after reset
    for (int s = 0; s < 4; s++) begin
      do_reset(s[1:0]);
      b = exp_base(s[1:0]);
      acc(1, exp_base(~s[1:0]), 8'h55, 0, 8'h00, "R2 flipped strap ignored");
      acc(1, b,     8'h55, 1, 8'h00, "R2 unlock at strap base");
      acc(1, b,     8'h12, 1, 8'h00, "R2 index 12");
      acc(0, b + 1, 8'h00, 1, b[7:0], "R2 strap low byte");
      acc(1, b,     8'h13, 1, 8'h00, "R2 index 13");
      acc(0, b + 1, 8'h00, 1, b[15:8], "R2 strap high byte");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule